// File: doc/BRIEF.md
# Serial Debug Shift Port

This block is the serial debug access point of a chip that runs on a two-phase clock. The two phases are modelled as alternating cycles of one system clock. The `ph_b` input is high on every phase-B cycle and low on every phase-A cycle. A debugger drives the port in phase A with five inputs: a hold qualifier, a shift command, an execute command, an active-low select and a serial data bit. The port samples these inputs only on the clock edge that ends a phase-B cycle, so their effect appears in the following A/B pair.

A shift moves the internal debug register one place toward bit 0. Bit 0 is always driven on the serial output. The bit arriving on the serial input is written into the top bit one phase B later. An execute raises a one-cycle strobe in the next phase A and presents the whole register on a parallel bus, so that a client can interpret it. A debug reset, also sampled at the end of phase B, returns the port to its idle state.

Top module: `dbg_shift_port`

## Requirements
- R1: After `rst_n` is released, `dbg_sdo`, `exec_strobe` and `exec_word` are all 0.
- R2: All control inputs are sampled only at the clock edge that ends a cycle with `ph_b`=1. Control values present only during a phase-A cycle have no effect.
- R3: A shift is accepted when `dbg_hold`=1, `dbg_sel_n`=0 and `dbg_shift`=1 at the end of phase B. The register then moves one bit toward bit 0, and bit W-1 becomes 0. `dbg_sdo` (register bit 0) shows the new bit 0 from the next phase A and holds it through the phase B after it.
- R4: At the end of the phase B that follows an accepted shift, `dbg_sdi` is written into bit W-1. If a further shift is accepted at that same edge, the bit is written first and the register is then shifted.
- R5: With `dbg_sel_n`=1, neither shift nor execute is accepted.
- R6: With `dbg_hold`=0, neither shift nor execute is accepted.
- R7: An accepted execute (`dbg_hold`=1, `dbg_sel_n`=0, `dbg_exec`=1) makes `exec_strobe` high for exactly the next phase-A cycle. During that cycle, `exec_word` equals the register.
- R8: When shift and execute are accepted at the same edge, `exec_word` shows the register after the shift, with bit W-1 reading 0.
- R9: `dbg_rst`=1 at the end of phase B clears the register, any pending serial-in load, `exec_strobe` and `exec_word`. It takes priority over shift and execute.
- R10: `exec_word` keeps its value until the next accepted execute or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_b | input | 1 | 1 during phase-B cycles, 0 during phase-A cycles |
| dbg_rst | input | 1 | Debug reset, sampled at the end of phase B |
| dbg_hold | input | 1 | Qualifier that must be 1 for shift or execute |
| dbg_shift | input | 1 | Shift the register by one bit |
| dbg_exec | input | 1 | Hand the register to the client |
| dbg_sel_n | input | 1 | Active-low select; 1 blocks shift and execute |
| dbg_sdi | input | 1 | Serial data in |
| dbg_sdo | output | 1 | Serial data out (register bit 0) |
| exec_strobe | output | 1 | One-cycle execute pulse in phase A |
| exec_word | output | W | Register value presented with the strobe |

## Verification
A shift and an execute can be accepted at the same phase-B edge. The serial-in load from a previous shift can also land on that edge. Table rows and directed steps assert shift and execute together, both on a fresh register and straight after another shift. The bench judges each case by comparing `exec_word` in the strobe cycle with the post-shift value it predicts. In that value, the top bit is 0 and the newly loaded bit has already moved down one place.

// File: rtl/dbg_shift_port.sv
module dbg_shift_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph_b,
  input  logic         dbg_rst,
  input  logic         dbg_hold,
  input  logic         dbg_shift,
  input  logic         dbg_exec,
  input  logic         dbg_sel_n,
  input  logic         dbg_sdi,
  output logic         dbg_sdo,
  output logic         exec_strobe,
  output logic [W-1:0] exec_word
);

  logic [W-1:0] sr, base, nxt;
  logic         pend;
  logic         gate, acc_sh, acc_ex;

  assign gate   = ph_b & dbg_hold & ~dbg_sel_n;
  assign acc_sh = gate & dbg_shift;
  assign acc_ex = gate & dbg_exec;
  assign base   = pend ? {dbg_sdi, sr[W-2:0]} : sr;
  assign nxt    = acc_sh ? {1'b0, base[W-1:1]} : base;
  assign dbg_sdo = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr          <= '0;
      pend        <= 1'b0;
      exec_strobe <= 1'b0;
      exec_word   <= '0;
    end else if (ph_b) begin
      if (dbg_rst) begin
        sr          <= '0;
        pend        <= 1'b0;
        exec_strobe <= 1'b0;
        exec_word   <= '0;
      end else begin
        sr          <= nxt;
        pend        <= acc_sh;
        exec_strobe <= acc_ex;
        if (acc_ex) exec_word <= nxt;
      end
    end else begin
      exec_strobe <= 1'b0;
    end
  end

  a_r3_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sh && !pend && !dbg_rst |=> sr == {1'b0, $past(sr[W-1:1])});
  a_r3_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_b |=> $stable(dbg_sdo));
  a_r4_fill_top: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b && pend && !acc_sh && !dbg_rst |=> sr[W-1] == $past(dbg_sdi));
  a_r5_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b && (dbg_sel_n || !dbg_hold) |=> !exec_strobe && !pend);
  a_r7_strobe_in_a: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |-> !ph_b);
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |=> !exec_strobe);
  a_r8_word_is_reg: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |-> exec_word == sr);
  a_r9_dbg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ph_b && dbg_rst |=> sr == '0 && !pend && !exec_strobe && exec_word == '0);
  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ex || (ph_b && dbg_rst)) |=> $stable(exec_word));

endmodule

// File: tb/dbg_shift_port_bench.sv
module dbg_shift_port_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, ph_b = 1'b0;
  logic dbg_rst = 0, dbg_hold = 0, dbg_shift = 0, dbg_exec = 0, dbg_sel_n = 1, dbg_sdi = 0;
  logic dbg_sdo, exec_strobe;
  logic [W-1:0] exec_word;
  int tests = 0, failed = 0, cyc = 0;

  logic [W-1:0] m_sr = '0, m_word = '0;
  logic m_pend = 1'b0, m_pulse = 1'b0;

  always #4 clk = ~clk;

  dbg_shift_port #(.W(W)) u_dbg_shift_port (
    .clk(clk), .rst_n(rst_n), .ph_b(ph_b), .dbg_rst(dbg_rst), .dbg_hold(dbg_hold),
    .dbg_shift(dbg_shift), .dbg_exec(dbg_exec), .dbg_sel_n(dbg_sel_n), .dbg_sdi(dbg_sdi),
    .dbg_sdo(dbg_sdo), .exec_strobe(exec_strobe), .exec_word(exec_word));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      tests++; failed++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // One A/B pair. a_junk drives shift/exec high only during the A half (R2).
  task automatic pair(input logic h, input logic s, input logic sh, input logic ex,
                      input logic din, input logic rs, input logic a_junk);
    logic sdo_a, acc_sh, acc_ex;
    logic [W-1:0] base;
    ph_b = 1'b0; dbg_hold = h; dbg_sel_n = s; dbg_sdi = din; dbg_rst = rs;
    dbg_shift = a_junk ? 1'b1 : sh; dbg_exec = a_junk ? 1'b1 : ex;
    sdo_a = dbg_sdo;
    chk("R7 strobe during A", {31'b0, exec_strobe}, {31'b0, m_pulse});
    @(negedge clk);
    ph_b = 1'b1; dbg_shift = sh; dbg_exec = ex;
    chk("R3 sdo held through B", {31'b0, dbg_sdo}, {31'b0, sdo_a});
    chk("R7 strobe single cycle", {31'b0, exec_strobe}, '0);
    @(negedge clk);
    acc_sh = h & ~s & sh; acc_ex = h & ~s & ex;
    if (rs) begin
      m_sr = '0; m_pend = 0; m_pulse = 0; m_word = '0;
    end else begin
      base = m_pend ? {din, m_sr[W-2:0]} : m_sr;
      m_sr = acc_sh ? {1'b0, base[W-1:1]} : base;
      m_pend = acc_sh; m_pulse = acc_ex;
      if (acc_ex) m_word = m_sr;
    end
    chk("R3 sdo after shift", {31'b0, dbg_sdo}, {31'b0, m_sr[0]});
    chk("R10/R8 exec_word", exec_word, m_word);
  endtask

  // {hold, sel_n, shift, exec, sdi, expected strobe}
  localparam logic [5:0] VEC [12] = '{
    6'b101010, 6'b101000, 6'b100111, 6'b111100, 6'b001110, 6'b101101,
    6'b100010, 6'b011000, 6'b101010, 6'b101000, 6'b100101, 6'b101111};

  localparam logic [W-1:0] PAT = 32'hA5C3_1E7F;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sdo reset", {31'b0, dbg_sdo}, '0);
    chk("R1 strobe reset", {31'b0, exec_strobe}, '0);
    chk("R1 word reset", exec_word, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      pair(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], 1'b0, 1'b0);
      chk(VEC[i][4] ? "R5 select blocks" : (!VEC[i][5] ? "R6 hold blocks" : "R7 strobe"),
          {31'b0, exec_strobe}, {31'b0, VEC[i][0]});
    end

    // R4: load a pattern serially, then execute; word shows the loaded bits
    for (int i = 0; i < W; i++) pair(1, 0, 1, 0, PAT[i], 0, 0);
    pair(1, 0, 0, 1, 1'b1, 0, 0);
    chk("R4 serial load", exec_word, {1'b1, PAT[W-1:1]});

    // R8: shift and execute together straight after a shift with pending load
    pair(1, 0, 1, 0, 1'b0, 0, 0);
    pair(1, 0, 1, 1, 1'b1, 0, 0);
    chk("R8 post-shift top bit", {31'b0, exec_word[W-1]}, '0);
    chk("R8 loaded bit moved down", {31'b0, exec_word[W-2]}, 32'd1);

    // R10: shifts without execute leave the word alone
    m_word = exec_word;
    repeat (4) pair(1, 0, 1, 0, 1'b1, 0, 0);
    chk("R10 word kept", exec_word, m_word);

    // R2: commands present only in phase A are ignored
    pair(1, 0, 0, 0, 1'b0, 0, 1);
    chk("R2 A-only exec ignored", {31'b0, exec_strobe}, '0);
    pair(1, 0, 0, 0, 1'b0, 0, 0);

    // R9: debug reset beats shift and execute
    pair(1, 0, 1, 1, 1'b1, 1, 0);
    chk("R9 strobe cleared", {31'b0, exec_strobe}, '0);
    chk("R9 word cleared", exec_word, '0);
    chk("R9 sdo cleared", {31'b0, dbg_sdo}, '0);
    pair(1, 0, 0, 1, 1'b1, 0, 0);
    chk("R9 no pending load", exec_word, '0);
    pair(1, 0, 0, 0, 1'b0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule